// File: doc/BRIEF.md
# Latched Fault Status and Alert Controller

This block gathers fifteen out-of-limit condition flags from a monitoring front end and holds each one in a sticky status bit. The bits live in two 8-bit status registers. An active-low alert line is pulled low whenever any latched bit is not masked. Software reaches the block through a small register port. Reading a status register clears those of its bits whose condition has already gone away. The port also reads and writes the two mask registers.

The intended service flow is as follows. Software sees the alert and reads status. It masks the offending source so the alert releases once the condition drops. Later it polls, and unmasks the source when its status bit has cleared. If the bit is still latched at that point, the alert returns at once. Bit 7 of the low mask register is an enable for the whole high mask register. While that bit is 0, the high mask register has no effect.

Top module: `alert_status_ctrl`

## Requirements
- R1: A status bit is 1 in the cycle after the clock edge at which its condition input is sampled high. Condition bits cond_i[6:0] feed status-low bits 6..0, and cond_i[14:7] feed status-high bits 7..0.
- R2: A latched status bit clears only at an edge where its register is read (rd_en with its address) and its condition is low. A read while the condition is high, or in the same cycle the condition rises, leaves the bit set.
- R3: A read of one status register never clears bits of the other.
- R4: alert_n is 0 exactly when at least one latched status bit is unmasked, and it is 1 otherwise.
- R5: A mask bit of 1 removes that source from alert_n only. The status bit still sets and clears as in R1 and R2.
- R6: Writing 0 to a mask bit whose status bit is still latched drives alert_n low again after that write edge.
- R7: Low mask bit 7 enables the high mask register. While it is 0, every high mask bit is treated as 0.
- R8: Read bit 7 of the status-low register is the OR of all status-high bits. It has no storage of its own and is not cleared by a read.
- R9: After reset, all status and mask registers read 0x00 and alert_n is 1.
- R10: The address map is 0 for status low, 1 for status high, 2 for mask low and 3 for mask high. rdata returns the addressed register in the same cycle as rd_en. Writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 15 | Out-of-limit condition flags, active high |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest case to reach is a read strobe that lands while a condition is still high, or in the very cycle it rises. Random flags drawn per cycle almost never line up with a read of the right register at the right time. Directed steps therefore hold a flag high across a read, drop it, and then read again. Further directed steps unmask a still-latched source to show the rearm. After these, a long random phase with sparse flags and frequent reads and mask writes is checked cycle by cycle against a bench model.

// File: rtl/alert_stat_pkg.sv
package alert_stat_pkg;
   localparam int ADDR_W = 2;
   typedef logic [ADDR_W-1:0] reg_addr_t;
   localparam reg_addr_t ADR_STAT_LO = 2'd0;
   localparam reg_addr_t ADR_STAT_HI = 2'd1;
   localparam reg_addr_t ADR_MASK_LO = 2'd2;
   localparam reg_addr_t ADR_MASK_HI = 2'd3;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond,
   input  logic         rd_clr,
   output logic [W-1:0] st
);
   if (W < 1) begin : g_bad_w
      $error("sticky_bank: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             st[i] <= 1'b0;
         else if (cond[i])       st[i] <= 1'b1;
         else if (rd_clr)        st[i] <= 1'b0;
      end

      assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
         cond[i] |=> st[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (st[i] && !rd_clr) |=> st[i]);
      assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!st[i] && !cond[i]) |=> !st[i]);
   end
endmodule

// File: rtl/mask_bank.sv
module mask_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] m_lo,
   output logic [W-1:0] m_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lo <= '0;
         m_hi <= '0;
      end else begin
         if (wr_lo) m_lo <= wdata;
         if (wr_hi) m_hi <= wdata;
      end
   end

   assert_wr_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (m_lo == $past(wdata)));
   assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi) |=> ($stable(m_lo) && $stable(m_hi)));
endmodule

// File: rtl/alert_merge.sv
module alert_merge #(
   parameter int W          = 8,
   parameter bit HI_GATE_EN = 1'b1
) (
   input  logic [W-2:0] st_lo,
   input  logic [W-1:0] st_hi,
   input  logic [W-1:0] m_lo,
   input  logic [W-1:0] m_hi,
   output logic         alert_n
);
   logic [W-1:0] eff_m_hi;

   if (HI_GATE_EN) begin : g_gated
      assign eff_m_hi = m_lo[W-1] ? m_hi : '0;
   end else begin : g_direct
      logic unused_gate;
      assign unused_gate = m_lo[W-1];
      assign eff_m_hi    = m_hi;
   end

   assign alert_n = ~((|(st_lo & ~m_lo[W-2:0])) | (|(st_hi & ~eff_m_hi)));
endmodule

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl #(
   parameter int DATA_W = 8,
   parameter int SRC_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  cond_i,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              alert_n
);
   import alert_stat_pkg::*;

   localparam int LO_W = DATA_W - 1;

   if (SRC_W != 2 * DATA_W - 1) begin : g_bad_src
      $error("alert_status_ctrl: SRC_W must equal 2*DATA_W-1");
   end

   logic [LO_W-1:0]   st_lo;
   logic [DATA_W-1:0] st_hi, m_lo, m_hi;
   logic              rd_lo, rd_hi;

   assign rd_lo = rd_en && (addr == ADR_STAT_LO);
   assign rd_hi = rd_en && (addr == ADR_STAT_HI);

   sticky_bank #(.W(LO_W)) u_st_lo (
      .clk(clk), .rst_n(rst_n), .cond(cond_i[LO_W-1:0]), .rd_clr(rd_lo), .st(st_lo));

   sticky_bank #(.W(DATA_W)) u_st_hi (
      .clk(clk), .rst_n(rst_n), .cond(cond_i[SRC_W-1:LO_W]), .rd_clr(rd_hi), .st(st_hi));

   mask_bank #(.W(DATA_W)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(wr_en && (addr == ADR_MASK_LO)),
      .wr_hi(wr_en && (addr == ADR_MASK_HI)),
      .wdata(wdata), .m_lo(m_lo), .m_hi(m_hi));

   alert_merge #(.W(DATA_W), .HI_GATE_EN(1'b1)) u_merge (
      .st_lo(st_lo), .st_hi(st_hi), .m_lo(m_lo), .m_hi(m_hi), .alert_n(alert_n));

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (addr)
            ADR_STAT_LO: rdata = {(|st_hi), st_lo};
            ADR_STAT_HI: rdata = st_hi;
            ADR_MASK_LO: rdata = m_lo;
            default:     rdata = m_hi;
         endcase
      end
   end

   assert_unmasked_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(st_lo & ~m_lo[LO_W-1:0])) |-> !alert_n);
   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_lo == '0) && (st_hi == '0)) |-> alert_n);
   assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_lo[DATA_W-1] && (st_hi != '0)) |-> !alert_n);
   assert_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !(|cond_i[LO_W-1:0])) |=> (st_lo == $past(st_lo)));
endmodule

// File: tb/tb_alert_status_ctrl.sv
module tb_alert_status_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] cond = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        alert_n;

   int total = 0, bad = 0, cyc = 0;
   logic [6:0] e1 = '0;
   logic [7:0] e2 = '0, em1 = '0, em2 = '0;

   always #4 clk = ~clk;

   alert_status_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .alert_n(alert_n));

   function automatic logic exp_alert();
      logic [7:0] mh;
      mh = em1[7] ? em2 : 8'h00;
      return ~((|(e1 & ~em1[6:0])) | (|(e2 & ~mh)));
   endfunction

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0:    return {(|e2), e1};
         2'd1:    return e2;
         2'd2:    return em1;
         default: return em2;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic step(input logic [14:0] c, input logic r, input logic w,
                       input logic [1:0] a, input logic [7:0] d, input string tag);
      @(negedge clk);
      cond = c; rd_en = r; wr_en = w; addr = a; wdata = d;
      #1;
      if (r) check({tag, " rdata"}, rdata, exp_rd(a));
      @(posedge clk);
      e1 = c[6:0]  | (e1 & ~({7{r && a == 2'd0}} & ~c[6:0]));
      e2 = c[14:7] | (e2 & ~({8{r && a == 2'd1}} & ~c[14:7]));
      if (w && a == 2'd2) em1 = d;
      if (w && a == 2'd3) em2 = d;
      #1;
      check({tag, " alert_n"}, {7'd0, alert_n}, {7'd0, exp_alert()});
   endtask

   task automatic rd(input logic [14:0] c, input logic [1:0] a, input string tag);
      step(c, 1'b1, 1'b0, a, 8'h00, tag);
   endtask

   task automatic wr(input logic [14:0] c, input logic [1:0] a, input logic [7:0] d, input string tag);
      step(c, 1'b0, 1'b1, a, d, tag);
   endtask

   initial begin
      while (cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1027));
      repeat (3) @(posedge clk);
      #1;
      check("R9 alert_n at reset", {7'd0, alert_n}, 8'h01);
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++) rd('0, a[1:0], "R9");

      // R1: a one-cycle pulse latches
      step(15'h0008, 1'b0, 1'b0, 2'd0, 8'h00, "R1");
      rd('0, 2'd0, "R1 read clears gone cond");
      rd('0, 2'd0, "R2 cleared");
      // R2: read while condition held keeps bit, and same-cycle rise
      step(15'h0001, 1'b0, 1'b0, 2'd0, 8'h00, "R2");
      rd(15'h0001, 2'd0, "R2 held read");
      rd('0, 2'd0, "R2 still set");
      rd('0, 2'd0, "R2 now clear");
      rd(15'h0002, 2'd0, "R2 rise on read");
      rd('0, 2'd0, "R2 kept after rise");
      rd('0, 2'd0, "R2 cleared");
      // R3 and R8: both registers set, read high only
      step(15'h0084, 1'b0, 1'b0, 2'd0, 8'h00, "R3");
      rd('0, 2'd1, "R3 read hi");
      rd('0, 2'd0, "R3 lo kept, R8 summary now 0");
      step(15'h4000, 1'b0, 1'b0, 2'd0, 8'h00, "R8");
      rd('0, 2'd0, "R8 summary set");
      rd('0, 2'd0, "R8 summary not cleared by lo read");
      wr('0, 2'd0, 8'hFF, "R10 write status ignored");
      wr('0, 2'd1, 8'h00, "R10 write status ignored");
      rd('0, 2'd1, "R10 status hi unchanged");
      rd('0, 2'd1, "R8 hi cleared");
      rd('0, 2'd0, "R8 summary gone");
      // R5 / R6: mask then rearm
      wr('0, 2'd2, 8'h04, "R10 mask lo write");
      step(15'h0004, 1'b0, 1'b0, 2'd0, 8'h00, "R5 masked alert high");
      rd('0, 2'd0, "R5 status still set");
      step(15'h0004, 1'b0, 1'b0, 2'd0, 8'h00, "R5");
      wr('0, 2'd2, 8'h00, "R6 unmask rearms");
      rd('0, 2'd0, "R6 read clears");
      // R7: high mask gated by low bit 7
      wr('0, 2'd3, 8'hFF, "R10 mask hi write");
      step(15'h0100, 1'b0, 1'b0, 2'd0, 8'h00, "R7 gate off alert low");
      wr('0, 2'd2, 8'h80, "R7 gate on alert high");
      rd('0, 2'd2, "R10 mask lo read");
      rd('0, 2'd3, "R10 mask hi read");
      wr('0, 2'd2, 8'h00, "R7 gate off again");
      rd('0, 2'd1, "R7 clear hi");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [14:0] c;
         logic [3:0]  op;
         c  = (($urandom % 4) == 0) ? 15'(1 << ($urandom % 15)) : 15'h0;
         op = 4'($urandom % 16);
         if (op < 7)       rd(c, 2'($urandom % 4), "R4 random read");
         else if (op < 9)  wr(c, 2'($urandom % 4), 8'($urandom), "R5 random write");
         else              step(c, 1'b0, 1'b0, 2'd0, 8'h00, "R4 random idle");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule